// File: doc/BRIEF.md
# Serial Stereo Frame Capture Buffer

This block takes a two-channel serial audio stream and turns it into frames for a downstream transform engine. The stream arrives on three asynchronous pins: a bit clock, a word-select line that marks left and right words, and a data line. The pins are synchronised into the system clock domain. The block assembles 16-bit samples and packs each left/right pair into one 32-bit word. It writes the words in order into a frame memory. When a frame of `FRAME_PAIRS` pairs is complete, the whole frame is streamed out. The left sample appears on the real-part output and the right sample on the imaginary-part output, so one complex transform can process both channels.

Capture does not stop while a frame is being handed over. The block passes through four states: store, flush, wait-for-release and drain. Pairs that arrive from the start of a flush until the consumer releases the memory are parked in a small side buffer. After the release, the buffer is written back into memory ahead of any newer pair, and then direct capture resumes. The consumer can pause the stream cycle by cycle. It frees the memory with a one-cycle acknowledge after the frame ends.

Top module: `audio_frame_capture`

## Requirements
- R1: While reset is held and after it is released, `flushing`, `out_valid`, `frame_done` and `buf_ovf` are low and the block is in its store state.
- R2: Serial bits are taken on each rising edge of `ser_clk`, most significant bit first. A word ends when `ser_ws` changes level. The bit sampled together with the new level is the first bit of the next word. `ser_ws` low marks a left word and high marks a right word.
- R3: A pair is kept only when both its left word and its right word held exactly 16 bits. A pair with a shorter or longer word is discarded and never appears at the output.
- R4: In each output word, the left sample comes out on `out_re` (memory bits [31:16]) and the right sample on `out_im` (bits [15:0]).
- R5: Once `FRAME_PAIRS` pairs are stored, the frame is streamed out in arrival order, at most one word per cycle, each marked by `out_valid`. `flushing` is high for every word of the frame except the last.
- R6: `out_valid` is never high in a cycle that directly follows a cycle in which `cons_hold` was high. Holding changes neither the order nor the content of the words.
- R7: `frame_done` is high for exactly one cycle, together with the last word of each frame, after exactly `FRAME_PAIRS` valid words.
- R8: Pairs that arrive between the start of a flush and the end of the drain go to the side buffer. After a `cons_ack` pulse in the wait state, they are written into memory before any later pair. No pair is lost or reordered while the buffer has room.
- R9: When a pair arrives while the side buffer is full and nothing leaves it, that pair is dropped and `buf_ovf` rises. `buf_ovf` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_ws | input | 1 | Word select, low for left, high for right (asynchronous) |
| ser_data | input | 1 | Serial data line (asynchronous) |
| cons_hold | input | 1 | Consumer stall: no read is issued in a cycle where it is high |
| cons_ack | input | 1 | Consumer releases the frame memory; used only in the wait state |
| flushing | output | 1 | Frame streaming in progress |
| out_valid | output | 1 | Output word valid |
| out_re | output | SAMPLE_W | Left sample of the output word (real part) |
| out_im | output | SAMPLE_W | Right sample of the output word (imaginary part) |
| frame_done | output | 1 | One-cycle pulse with the last word of a frame |
| buf_ovf | output | 1 | Sticky side-buffer overflow flag |

## Verification
A wrong write address or a wrong drain order shows up at the output as a misplaced or repeated pair. Because the frame is short, it appears within one frame of the fault. A bit counter that is off by one either drops every pair, so no frame ever completes, or lets malformed pairs through, which shows as extra words in the next frame. A controller stuck in the wait or drain state stops `frame_done` for good. A side buffer that loses or duplicates entries shifts every later word against the expected sequence.

// File: rtl/afc_pkg.sv
// Shared types for the serial frame capture block.
package afc_pkg;
    // Controller states: direct capture, frame readout, wait for release, buffer drain
    typedef enum logic [1:0] {
        ST_STORE = 2'd0,
        ST_FLUSH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DRAIN = 2'd3
    } afc_state_e;
endpackage

// File: rtl/afc_serial_rx.sv
// Serial receiver: synchronises the three serial pins into clk, samples data
// on each rising bit-clock edge, counts bits per word and emits a packed
// left/right pair when a right word closes. Assumes the bit clock is slower
// than clk/4 so that every edge is seen by the two-flop synchroniser.
module afc_serial_rx #(
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_ws,
    input  logic                  ser_data,
    output logic                  pair_valid,
    output logic [2*SAMPLE_W-1:0] pair_data
);
    localparam int CW = $clog2(SAMPLE_W) + 2;
    localparam logic [CW-1:0] FULL_CNT = CW'(SAMPLE_W);

    logic [2:0]          sck_q;
    logic [1:0]          ws_q, sd_q;
    logic                ws_prev;
    logic [SAMPLE_W-1:0] shreg, left_hold;
    logic                left_ok;
    logic [CW-1:0]       bit_cnt;
    logic                sck_rise;

    // two-flop synchronisers plus an edge-detect stage on the bit clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= '0;
            ws_q  <= '0;
            sd_q  <= '0;
        end else begin
            sck_q <= {sck_q[1:0], ser_clk};
            ws_q  <= {ws_q[0], ser_ws};
            sd_q  <= {sd_q[0], ser_data};
        end
    end

    assign sck_rise = sck_q[1] & ~sck_q[2];

    // shift, count and close words on a word-select change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev    <= 1'b0;
            shreg      <= '0;
            left_hold  <= '0;
            left_ok    <= 1'b0;
            bit_cnt    <= '0;
            pair_valid <= 1'b0;
            pair_data  <= '0;
        end else begin
            pair_valid <= 1'b0;
            if (sck_rise) begin
                ws_prev <= ws_q[1];
                shreg   <= {shreg[SAMPLE_W-2:0], sd_q[1]};
                if (ws_q[1] != ws_prev) begin
                    bit_cnt <= CW'(1);
                    if (!ws_prev) begin
                        left_hold <= shreg;
                        left_ok   <= (bit_cnt == FULL_CNT);
                    end else begin
                        pair_valid <= left_ok && (bit_cnt == FULL_CNT);
                        pair_data  <= {left_hold, shreg};
                        left_ok    <= 1'b0;
                    end
                end else if (bit_cnt != '1) begin
                    bit_cnt <= bit_cnt + CW'(1);
                end
            end
        end
    end

    // R3
    pair_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(bit_cnt) == FULL_CNT);
endmodule

// File: rtl/afc_side_fifo.sv
// Side buffer: small first-in first-out store that holds pairs arriving while
// the frame memory is busy. A push into a full buffer with no pop in the same
// cycle is dropped and raises a sticky overflow flag.
module afc_side_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [PW:0]   DEPTH_C  = (PW + 1)'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [PW:0]      count;
    logic             full, do_push, do_pop;

    assign full     = (count == DEPTH_C);
    assign empty    = (count == '0);
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);
    assign pop_data = store[rptr];

    // storage array write port
    always_ff @(posedge clk) begin
        if (do_push) store[wptr] <= push_data;
    end

    // pointers, occupancy and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + PW'(1);
            if (do_pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + PW'(1);
            count <= count + (PW + 1)'(do_push) - (PW + 1)'(do_pop);
            if (push && !do_push) ovf <= 1'b1;
        end
    end

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> ovf);
    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
endmodule

// File: rtl/afc_frame_mem.sv
// Frame memory: simple dual-port array with one write port and one
// registered read port (one cycle read latency). No reset on contents.
module afc_frame_mem #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // write port and registered read port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/afc_capture_ctrl.sv
// Capture controller: four-state sequencer with write and read address
// counters. It routes each arriving pair either straight into memory or into
// the side buffer, streams a full frame out under consumer hold, and drains
// the side buffer after the consumer releases the memory.
module afc_capture_ctrl
    import afc_pkg::*;
#(
    parameter int FRAME_PAIRS = 256,
    parameter int AW          = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pair_valid,
    input  logic       fifo_empty,
    input  logic       cons_hold,
    input  logic       cons_ack,
    output logic       wr_en,
    output logic       wr_from_fifo,
    output logic       fifo_push,
    output logic [AW-1:0] wr_addr,
    output logic       rd_en,
    output logic       rd_last,
    output logic [AW-1:0] rd_addr,
    output afc_state_e state
);
    localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_PAIRS - 1);

    logic direct;

    assign direct       = (state == ST_STORE) || (state == ST_DRAIN && fifo_empty);
    assign wr_from_fifo = (state == ST_DRAIN) && !fifo_empty;
    assign fifo_push    = pair_valid && !direct;
    assign wr_en        = (pair_valid && direct) || wr_from_fifo;
    assign rd_en        = (state == ST_FLUSH) && !cons_hold;
    assign rd_last      = rd_en && (rd_addr == LAST_IDX);

    // state sequencing and address generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_STORE;
            wr_addr <= '0;
            rd_addr <= '0;
        end else begin
            if (wr_en) wr_addr <= (wr_addr == LAST_IDX) ? '0 : wr_addr + AW'(1);
            unique case (state)
                ST_STORE: if (wr_en && wr_addr == LAST_IDX) state <= ST_FLUSH;
                ST_FLUSH: if (rd_en) begin
                    rd_addr <= rd_last ? '0 : rd_addr + AW'(1);
                    if (rd_last) state <= ST_WAIT;
                end
                ST_WAIT:  if (cons_ack) state <= ST_DRAIN;
                ST_DRAIN: begin
                    if (wr_en && wr_addr == LAST_IDX) state <= ST_FLUSH;
                    else if (fifo_empty)             state <= ST_STORE;
                end
                default:  state <= ST_STORE;
            endcase
        end
    end

    // R8
    store_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE) |-> fifo_empty);
    // R5
    flush_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_FLUSH) |-> $past(wr_en));
endmodule

// File: rtl/audio_frame_capture.sv
// Top level: serial receiver, side buffer, frame memory and controller.
// Output words are presented one cycle after their read is issued.
// Assumes FRAME_PAIRS <= MEM_DEPTH and BUF_DEPTH >= 1.
module audio_frame_capture
    import afc_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int FRAME_PAIRS = 256,
    parameter int MEM_DEPTH   = 1024,
    parameter int BUF_DEPTH   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                ser_ws,
    input  logic                ser_data,
    input  logic                cons_hold,
    input  logic                cons_ack,
    output logic                flushing,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_re,
    output logic [SAMPLE_W-1:0] out_im,
    output logic                frame_done,
    output logic                buf_ovf
);
    localparam int WW = 2 * SAMPLE_W;
    localparam int AW = $clog2(MEM_DEPTH);

    logic          pair_valid, fifo_empty, wr_en, wr_from_fifo, fifo_push;
    logic          rd_en, rd_last;
    logic [WW-1:0] pair_data, fifo_data, wdata, rdata;
    logic [AW-1:0] wr_addr, rd_addr;
    afc_state_e    state;

    afc_serial_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_ws(ser_ws),
        .ser_data(ser_data), .pair_valid(pair_valid), .pair_data(pair_data));

    afc_side_fifo #(.WIDTH(WW), .DEPTH(BUF_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(pair_data),
        .pop(wr_from_fifo), .pop_data(fifo_data), .empty(fifo_empty), .ovf(buf_ovf));

    afc_capture_ctrl #(.FRAME_PAIRS(FRAME_PAIRS), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .fifo_empty(fifo_empty),
        .cons_hold(cons_hold), .cons_ack(cons_ack), .wr_en(wr_en),
        .wr_from_fifo(wr_from_fifo), .fifo_push(fifo_push), .wr_addr(wr_addr),
        .rd_en(rd_en), .rd_last(rd_last), .rd_addr(rd_addr), .state(state));

    assign wdata = wr_from_fifo ? fifo_data : pair_data;

    afc_frame_mem #(.WIDTH(WW), .DEPTH(MEM_DEPTH), .AW(AW)) u_mem (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wdata),
        .re(rd_en), .raddr(rd_addr), .rdata(rdata));

    assign flushing = (state == ST_FLUSH);
    assign out_re   = rdata[WW-1:SAMPLE_W];
    assign out_im   = rdata[SAMPLE_W-1:0];

    // output strobes aligned with the registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            out_valid  <= rd_en;
            frame_done <= rd_last;
        end
    end

    // R6
    hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(!cons_hold));
    // R7
    done_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> out_valid);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

// File: tb/audio_frame_capture_test.sv
`timescale 1ns/1ps
module audio_frame_capture_test;
    localparam int SW = 16;
    localparam int FP = 8;
    localparam int MD = 16;
    localparam int BD = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, ser_clk, ser_ws, ser_data, cons_hold, cons_ack;
    logic flushing, out_valid, frame_done, buf_ovf;
    logic [SW-1:0] out_re, out_im;

    audio_frame_capture #(.SAMPLE_W(SW), .FRAME_PAIRS(FP), .MEM_DEPTH(MD), .BUF_DEPTH(BD)) uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_ws(ser_ws), .ser_data(ser_data),
        .cons_hold(cons_hold), .cons_ack(cons_ack), .flushing(flushing),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .frame_done(frame_done), .buf_ovf(buf_ovf));

    int tests_run = 0;
    int tests_failed = 0;
    logic [31:0] exp_q[$];
    int exp_idx = 0;
    int frames_seen = 0;
    int words_in_frame = 0;
    bit hold_mode = 1'b0;
    bit ack_block = 1'b0;
    int ack_req = 0;
    int ack_served = 0;
    bit mon_en = 1'b0;
    logic [31:0] seed = 32'h1234_5678;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] rnd16();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[31:16];
    endfunction

    // one serial word, MSB first, word select applied with the first bit
    task automatic send_word(input bit ws, input logic [31:0] d, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_ws   = ws;
            ser_data = d[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_pair(input logic [15:0] l, input logic [15:0] r, input bit keep);
        if (keep) exp_q.push_back({l, r});
        send_word(1'b0, {16'h0, l}, 16);
        send_word(1'b1, {16'h0, r}, 16);
    endtask

    task automatic wait_frames(input int target);
        while (frames_seen < target) send_pair(rnd16(), rnd16(), 1'b1);
    endtask

    // send until the most recent pair completes a frame (it closes on the next word)
    task automatic align_frame();
        while (exp_q.size() == 0 || (exp_q.size() % FP) != 0) send_pair(rnd16(), rnd16(), 1'b1);
    endtask

    // output monitor: order, packing, flush flag, hold gap and frame framing
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en && rst_n) begin
                if (out_valid) begin
                    if (exp_idx < exp_q.size())
                        check({out_re, out_im} == exp_q[exp_idx], "R4/R5/R8 word",
                              {32'h0, out_re, out_im}, {32'h0, exp_q[exp_idx]});
                    else
                        check(1'b0, "R3/R5 unexpected word", {32'h0, out_re, out_im}, 64'h0);
                    exp_idx++;
                    words_in_frame++;
                    check(!cons_hold, "R6 word after hold", 64'(cons_hold), 64'h0);
                    if (!frame_done) check(flushing, "R5 flushing", 64'(flushing), 64'h1);
                end
                if (frame_done) begin
                    check(out_valid, "R7 done with word", 64'(out_valid), 64'h1);
                    check(words_in_frame == FP, "R7 words per frame", 64'(words_in_frame), 64'(FP));
                    words_in_frame = 0;
                    frames_seen++;
                end
            end
        end
    end

    // consumer release: automatic after each frame unless blocked, or on request
    initial begin
        cons_ack = 1'b0;
        forever begin
            @(negedge clk);
            cons_ack = 1'b0;
            if (ack_req != ack_served) begin
                ack_served = ack_req;
                cons_ack = 1'b1;
            end else if (frame_done && !ack_block) begin
                cons_ack = 1'b1;
            end
        end
    end

    // consumer stall pattern
    initial begin
        int hc = 0;
        cons_hold = 1'b0;
        forever begin
            @(negedge clk);
            hc++;
            cons_hold = hold_mode && ((hc % 3) != 0);
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        ser_clk = 1'b0; ser_ws = 1'b0; ser_data = 1'b0;
        repeat (4) @(negedge clk);
        check(!flushing && !out_valid && !frame_done && !buf_ovf, "R1 in reset",
              {60'h0, flushing, out_valid, frame_done, buf_ovf}, 64'h0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(!flushing && !out_valid && !frame_done && !buf_ovf, "R1 after reset",
              {60'h0, flushing, out_valid, frame_done, buf_ovf}, 64'h0);
        mon_en = 1'b1;
    endtask

    // R2 R4 R5 R7: fixed corner patterns, then a full frame
    task automatic t_basic();
        int start = frames_seen;
        send_pair(16'hFFFF, 16'h0000, 1'b1);
        send_pair(16'h0000, 16'hFFFF, 1'b1);
        send_pair(16'h8001, 16'h7FFE, 1'b1);
        send_pair(16'hA5A5, 16'h5A5A, 1'b1);
        wait_frames(start + 1);
        check(frames_seen == start + 1, "R5 one frame", 64'(frames_seen - start), 64'h1);
        check(exp_idx == FP, "R2 words consumed", 64'(exp_idx), 64'(FP));
    endtask

    // R6: stream a frame under a stall pattern
    task automatic t_hold();
        int start = frames_seen;
        hold_mode = 1'b1;
        wait_frames(start + 1);
        hold_mode = 1'b0;
        check(exp_idx == (start + 1) * FP, "R6 words after hold", 64'(exp_idx), 64'((start + 1) * FP));
    endtask

    // R3: short and long words discard their pair
    task automatic t_malformed();
        int start = frames_seen;
        send_word(1'b0, 32'h0000_1357, 15);
        send_word(1'b1, 32'h0000_2468, 16);
        send_word(1'b0, 32'h0000_1111, 16);
        send_word(1'b1, 32'h0001_2222, 17);
        send_pair(16'hC3C3, 16'h3C3C, 1'b1);
        wait_frames(start + 1);
        check(exp_idx == (start + 1) * FP, "R3 malformed dropped", 64'(exp_idx), 64'((start + 1) * FP));
    endtask

    // R8: pairs parked while the memory is not released, then drained in order
    task automatic t_buffered();
        int start;
        align_frame();
        start = frames_seen;
        ack_block = 1'b1;
        send_pair(16'h0101, 16'h0202, 1'b1);
        send_pair(16'h0303, 16'h0404, 1'b1);
        send_pair(16'h0505, 16'h0606, 1'b1);
        check(frames_seen == start + 1 && !flushing, "R8 waiting", 64'(frames_seen - start), 64'h1);
        check(!buf_ovf, "R9 no overflow within depth", 64'(buf_ovf), 64'h0);
        ack_req++;
        ack_block = 1'b0;
        wait_frames(start + 2);
        check(exp_idx == (start + 2) * FP, "R8 drained order", 64'(exp_idx), 64'((start + 2) * FP));
    endtask

    // R9: overfill the side buffer; the newest pair is lost and the flag sticks
    task automatic t_overflow();
        int start;
        align_frame();
        start = frames_seen;
        ack_block = 1'b1;
        for (int i = 0; i < BD; i++) send_pair(rnd16(), rnd16(), 1'b1);
        send_pair(16'hDEAD, 16'hBEEF, 1'b0);
        send_pair(16'h1234, 16'h5678, 1'b1);
        check(buf_ovf, "R9 overflow flag", 64'(buf_ovf), 64'h1);
        check(!out_valid && !flushing, "R8 idle while waiting", {62'h0, out_valid, flushing}, 64'h0);
        ack_req++;
        ack_block = 1'b0;
        wait_frames(start + 2);
        check(exp_idx == (start + 2) * FP, "R9 newest dropped", 64'(exp_idx), 64'((start + 2) * FP));
        check(buf_ovf, "R9 flag sticky", 64'(buf_ovf), 64'h1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_malformed();
        t_buffered();
        t_overflow();
        repeat (20) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end
endmodule